// File: doc/BRIEF.md
# Dual Accumulator ALU with Saturation Tracking

This block is the arithmetic core of a small fixed-point signal processor. It holds two 16-bit two's complement accumulators, A and B, and a six-bit flag set for each. Every cycle it can apply one of sixteen operations to the accumulator chosen by `accSel`. The second operand is picked from four sources: a RAM word, the internal data bus, the high word of the multiplier product, or the low word of the product. In the same cycle an internal bus move may load `busWord` into either accumulator. If that move targets the accumulator the ALU would write, the move wins and the ALU operation does nothing.

Beyond the usual sign, carry, zero and overflow flags, each accumulator keeps an auxiliary overflow flag and an auxiliary sign flag. Together they follow a chain of additions and subtractions whose partial sums leave the 16-bit range and later return to it. A sign register follows the auxiliary sign of accumulator A. It presents the clamping constant 7FFFh for a positive true result or 8000h for a negative one, so software can limit an out-of-range value. Work on accumulator B never disturbs that register.

Top module: `dual_acc_alu`

## Requirements
- R1: After the asynchronous active-low reset `rstN`, both accumulators and both flag sets are zero and `satConst` reads 7FFFh.
- R2: `opCode` encodes: 0 NOP, 1 OR, 2 AND, 3 XOR, 4 SUB, 5 ADD, 6 SBB, 7 ADC, 8 DEC, 9 INC, 10 one's complement, 11 arithmetic shift right by 1 (sign bit kept), 12 shift left by 1, 13 shift left by 2, 14 shift left by 4 (left shifts fill with zero), 15 swap of the upper and lower bytes. The result is written to the selected accumulator at the next clock edge.
- R3: `srcSel` picks the second operand: 0 `ramWord`, 1 `busWord`, 2 `mulHigh`, 3 `mulLow`. Only OR, AND, XOR, SUB, ADD, SBB and ADC use it. DEC, INC, complement, the shifts and the swap ignore it.
- R4: ADD and ADC set C to the carry out. SUB and SBB set C to the borrow, meaning the unsigned operand (plus C for SBB) is greater than the accumulator. INC and DEC count as addition and subtraction of one. ADC and SBB use the C flag of the accumulator being operated on.
- R5: `flagsA` and `flagsB` are laid out as bit 5 S1, bit 4 S0, bit 3 C, bit 2 Z, bit 1 OV1, bit 0 OV0. Every operation other than NOP sets S0 to the result's sign bit and Z when the result is zero. OV0 is the signed overflow of that operation.
- R6: OR, AND, XOR, complement, the shifts and the swap clear C, OV0 and OV1.
- R7: Each arithmetic operation (ADD, SUB, ADC, SBB, INC, DEC) toggles OV1 when it overflows and otherwise leaves OV1 unchanged. When OV1 ends up clear, S1 equals S0. When OV1 ends up set, S1 is the inverse of S0 if this operation overflowed, and otherwise S1 keeps its previous value.
- R8: A NOP changes no accumulator and no flag.
- R9: The ALU writes only the accumulator selected by `accSel` (0 = A, 1 = B) and only that accumulator's flags.
- R10: With `moveEn` high, the accumulator chosen by `moveSel` (0 = A, 1 = B) takes `busWord` at the next edge and its flags are left unchanged. If `moveSel` equals `accSel`, the ALU operation in that cycle acts as NOP.
- R11: The sign register takes S1 of accumulator A whenever the ALU updates A. `satConst` is 8000h when that bit is 1 and 7FFFh when it is 0. Operations on B never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | ALU operation code |
| srcSel | input | 2 | Second operand source select |
| accSel | input | 1 | Accumulator the ALU works on (0 = A, 1 = B) |
| moveEn | input | 1 | A bus move into an accumulator happens this cycle |
| moveSel | input | 1 | Accumulator the bus move writes (0 = A, 1 = B) |
| ramWord | input | 16 | RAM operand |
| busWord | input | 16 | Internal bus value, operand and move data |
| mulHigh | input | 16 | Multiplier product high word |
| mulLow | input | 16 | Multiplier product low word |
| accA | output | 16 | Accumulator A |
| accB | output | 16 | Accumulator B |
| flagsA | output | 6 | Flags of A {S1,S0,C,Z,OV1,OV0} |
| flagsB | output | 6 | Flags of B {S1,S0,C,Z,OV1,OV0} |
| satConst | output | 16 | Clamping constant from the sign register |

## Verification
Two functions can collide in one cycle: a bus move into an accumulator and an ALU operation. The move may hit the same accumulator the ALU targets, which must suppress the ALU, or the other accumulator, in which case both writes land. Directed cycles set `moveEn` with `moveSel` both equal to and different from `accSel` under non-NOP opcodes. Random cycles raise `moveEn` often enough that both cases recur under every opcode. The behavioural model applies the ALU result first and the move second, and any difference in the accumulators, the flags or `satConst` on the following cycle is reported.

// File: rtl/dual_acc_alu_pkg.sv
package dual_acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_OR   = 4'd1,
    OP_AND  = 4'd2,
    OP_XOR  = 4'd3,
    OP_SUB  = 4'd4,
    OP_ADD  = 4'd5,
    OP_SBB  = 4'd6,
    OP_ADC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_INC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SHR1 = 4'd11,
    OP_SHL1 = 4'd12,
    OP_SHL2 = 4'd13,
    OP_SHL4 = 4'd14,
    OP_SWAP = 4'd15
  } aluOp_e;

  typedef struct packed {
    logic s1;
    logic s0;
    logic c;
    logic z;
    logic ov1;
    logic ov0;
  } accFlags_t;

  typedef struct packed {
    aluOp_e op;
    logic   isArith;
    logic   isSub;
    logic   useOperand;
    logic   useCarry;
    logic   commitA;
    logic   commitB;
    logic   loadA;
    logic   loadB;
  } ctrlStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import dual_acc_alu_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        accSel,
  input  logic        moveEn,
  input  logic        moveSel,
  output ctrlStrobe_t strobe
);

  aluOp_e op;
  logic   suppressed;
  logic   aluActive;

  always_comb begin
    op         = aluOp_e'(opCode);
    suppressed = moveEn && (moveSel == accSel);
    aluActive  = (op != OP_NOP) && !suppressed;

    strobe.op         = op;
    strobe.isArith    = (op == OP_SUB) || (op == OP_ADD) || (op == OP_SBB) ||
                        (op == OP_ADC) || (op == OP_DEC) || (op == OP_INC);
    strobe.isSub      = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
    strobe.useOperand = (op == OP_OR)  || (op == OP_AND) || (op == OP_XOR) ||
                        (op == OP_SUB) || (op == OP_ADD) || (op == OP_SBB) ||
                        (op == OP_ADC);
    strobe.useCarry   = (op == OP_SBB) || (op == OP_ADC);
    strobe.commitA    = aluActive && !accSel;
    strobe.commitB    = aluActive && accSel;
    strobe.loadA      = moveEn && !moveSel;
    strobe.loadB      = moveEn && moveSel;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import dual_acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  accFlags_t         flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output accFlags_t         flagsOut
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] addendB;
  logic [DATA_W-1:0] addendEff;
  logic              carryRaw;
  logic              carryEff;
  logic [DATA_W:0]   sumWide;
  logic              arithCarry;
  logic              arithOvf;
  logic [DATA_W-1:0] logicRes;
  logic              newOv1;
  logic              newS0;

  always_comb begin
    addendB    = strobe.useOperand ? operandIn : DATA_W'(1);
    carryRaw   = strobe.useCarry & flagsIn.c;
    addendEff  = strobe.isSub ? ~addendB : addendB;
    carryEff   = strobe.isSub ? ~carryRaw : carryRaw;
    sumWide    = {1'b0, accIn} + {1'b0, addendEff} + {{DATA_W{1'b0}}, carryEff};
    arithCarry = strobe.isSub ? ~sumWide[DATA_W] : sumWide[DATA_W];
    arithOvf   = (accIn[MSB] == addendEff[MSB]) && (sumWide[MSB] != accIn[MSB]);
  end

  always_comb begin
    case (strobe.op)
      OP_OR:   logicRes = accIn | operandIn;
      OP_AND:  logicRes = accIn & operandIn;
      OP_XOR:  logicRes = accIn ^ operandIn;
      OP_CPL:  logicRes = ~accIn;
      OP_SHR1: logicRes = {accIn[MSB], accIn[MSB:1]};
      OP_SHL1: logicRes = {accIn[MSB-1:0], 1'b0};
      OP_SHL2: logicRes = {accIn[MSB-2:0], 2'b00};
      OP_SHL4: logicRes = {accIn[MSB-4:0], 4'b0000};
      OP_SWAP: logicRes = {accIn[HALF_W-1:0], accIn[MSB:HALF_W]};
      default: logicRes = accIn;
    endcase
  end

  always_comb begin
    resultOut = strobe.isArith ? sumWide[DATA_W-1:0] : logicRes;
    newS0     = resultOut[MSB];
    flagsOut.s0 = newS0;
    flagsOut.z  = (resultOut == '0);
    if (strobe.isArith) begin
      newOv1       = flagsIn.ov1 ^ arithOvf;
      flagsOut.c   = arithCarry;
      flagsOut.ov0 = arithOvf;
      flagsOut.ov1 = newOv1;
      if (!newOv1)
        flagsOut.s1 = newS0;
      else if (arithOvf)
        flagsOut.s1 = ~newS0;
      else
        flagsOut.s1 = flagsIn.s1;
    end else begin
      newOv1       = 1'b0;
      flagsOut.c   = 1'b0;
      flagsOut.ov0 = 1'b0;
      flagsOut.ov1 = 1'b0;
      flagsOut.s1  = newS0;
    end
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import dual_acc_alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SRC_NUM  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic                       accSel,
  input  logic [$clog2(SRC_NUM)-1:0] srcSel,
  input  logic [DATA_W-1:0]          srcWords [SRC_NUM],
  input  logic [DATA_W-1:0]          moveData,
  output logic [DATA_W-1:0]          accA,
  output logic [DATA_W-1:0]          accB,
  output accFlags_t                  flagsA,
  output accFlags_t                  flagsB,
  output logic [DATA_W-1:0]          satConst
);

  localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SAT_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] accCur;
  accFlags_t         flagsCur;
  logic [DATA_W-1:0] aluResult;
  accFlags_t         aluFlags;
  logic              sgnNeg;

  always_comb begin
    operand  = srcWords[srcSel];
    accCur   = accSel ? accB : accA;
    flagsCur = accSel ? flagsB : flagsA;
  end

  acc_alu_core #(.DATA_W(DATA_W)) uCore (
    .strobe    (strobe),
    .accIn     (accCur),
    .operandIn (operand),
    .flagsIn   (flagsCur),
    .resultOut (aluResult),
    .flagsOut  (aluFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accA   <= '0;
      flagsA <= '0;
      sgnNeg <= 1'b0;
    end else if (strobe.loadA) begin
      accA <= moveData;
    end else if (strobe.commitA) begin
      accA   <= aluResult;
      flagsA <= aluFlags;
      sgnNeg <= aluFlags.s1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accB   <= '0;
      flagsB <= '0;
    end else if (strobe.loadB) begin
      accB <= moveData;
    end else if (strobe.commitB) begin
      accB   <= aluResult;
      flagsB <= aluFlags;
    end
  end

  assign satConst = sgnNeg ? SAT_NEG : SAT_POS;

  AST_SAT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (satConst == SAT_POS) || (satConst == SAT_NEG)); // R11

  AST_B_KEEPS_SGN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitB |=> $stable(satConst)); // R11

  AST_MOVE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadA |=> (accA == $past(moveData)) && $stable(flagsA)); // R10

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_NOP) && !strobe.loadA && !strobe.loadB
      |=> $stable(accA) && $stable(accB) && $stable(flagsA) && $stable(flagsB)); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitA |=> (flagsA.z == (accA == '0)) && (flagsA.s0 == accA[DATA_W-1])); // R5

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitB && !strobe.isArith |=> !flagsB.c && !flagsB.ov0 && !flagsB.ov1); // R6

  AST_S1_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitA |=> flagsA.ov1 || (flagsA.s1 == flagsA.s0)); // R7

endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import dual_acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [1:0]        srcSel,
  input  logic              accSel,
  input  logic              moveEn,
  input  logic              moveSel,
  input  logic [DATA_W-1:0] ramWord,
  input  logic [DATA_W-1:0] busWord,
  input  logic [DATA_W-1:0] mulHigh,
  input  logic [DATA_W-1:0] mulLow,
  output logic [DATA_W-1:0] accA,
  output logic [DATA_W-1:0] accB,
  output logic [5:0]        flagsA,
  output logic [5:0]        flagsB,
  output logic [DATA_W-1:0] satConst
);

  localparam int SRC_NUM = 4;

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] srcWords [SRC_NUM];
  accFlags_t         flagsAInt;
  accFlags_t         flagsBInt;

  always_comb begin
    srcWords[0] = ramWord;
    srcWords[1] = busWord;
    srcWords[2] = mulHigh;
    srcWords[3] = mulLow;
  end

  acc_alu_ctrl uCtrl (
    .opCode  (opCode),
    .accSel  (accSel),
    .moveEn  (moveEn),
    .moveSel (moveSel),
    .strobe  (strobe)
  );

  acc_alu_dp #(.DATA_W(DATA_W), .SRC_NUM(SRC_NUM)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .accSel   (accSel),
    .srcSel   (srcSel),
    .srcWords (srcWords),
    .moveData (busWord),
    .accA     (accA),
    .accB     (accB),
    .flagsA   (flagsAInt),
    .flagsB   (flagsBInt),
    .satConst (satConst)
  );

  assign flagsA = flagsAInt;
  assign flagsB = flagsBInt;

endmodule

// File: tb/dual_acc_alu_test.sv
module dual_acc_alu_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  opCode;
  logic [1:0]  srcSel;
  logic        accSel, moveEn, moveSel;
  logic [15:0] ramWord, busWord, mulHigh, mulLow;
  logic [15:0] accA, accB, satConst;
  logic [5:0]  flagsA, flagsB;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  int       mAcc [2];
  bit [5:0] mFlg [2];
  bit       mSgn;

  always #2.5 clk = ~clk;

  dual_acc_alu uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .srcSel(srcSel), .accSel(accSel),
    .moveEn(moveEn), .moveSel(moveSel), .ramWord(ramWord), .busWord(busWord),
    .mulHigh(mulHigh), .mulLow(mulLow), .accA(accA), .accB(accB),
    .flagsA(flagsA), .flagsB(flagsB), .satConst(satConst)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  // Behavioural reference: applies one cycle of stimulus to the model state.
  task automatic modelStep(input int op, input int src, input int sel, input int mv,
                           input int mvSel, input int ram, input int bus, input int mh, input int ml);
    int a, b, cin, wide, exact, r;
    bit [5:0] f;
    bit arith, ovf, s0, ov1;
    if (op != 0 && !(mv != 0 && mvSel == sel)) begin
      a = mAcc[sel];
      f = mFlg[sel];
      case (src)
        0: b = ram;
        1: b = bus;
        2: b = mh;
        default: b = ml;
      endcase
      cin = (op == 6 || op == 7) ? int'(f[3]) : 0;
      arith = (op >= 4 && op <= 9);
      if (op == 8 || op == 9) b = 1;
      ovf = 0;
      r = 0;
      if (op == 4 || op == 6 || op == 8) begin
        wide  = a - b - cin;
        exact = toSigned(a) - toSigned(b) - cin;
        f[3]  = (wide < 0);
        r     = wide & 16'hFFFF;
        ovf   = (exact > 32767) || (exact < -32768);
      end else if (arith) begin
        wide  = a + b + cin;
        exact = toSigned(a) + toSigned(b) + cin;
        f[3]  = (wide > 65535);
        r     = wide & 16'hFFFF;
        ovf   = (exact > 32767) || (exact < -32768);
      end else begin
        case (op)
          1: r = a | b;
          2: r = a & b;
          3: r = a ^ b;
          10: r = (~a) & 16'hFFFF;
          11: r = (a >> 1) | (a & 16'h8000);
          12: r = (a * 2) & 16'hFFFF;
          13: r = (a * 4) & 16'hFFFF;
          14: r = (a * 16) & 16'hFFFF;
          default: r = ((a & 255) * 256) + (a / 256);
        endcase
        f[3] = 0;
      end
      s0 = (r >= 32768);
      if (arith) ov1 = f[1] ^ ovf; else ov1 = 0;
      if (!ov1)      f[5] = s0;
      else if (ovf)  f[5] = !s0;
      f[4] = s0;
      f[2] = (r == 0);
      f[1] = ov1;
      f[0] = ovf;
      mAcc[sel] = r;
      mFlg[sel] = f;
      if (sel == 0) mSgn = f[5];
    end
    if (mv != 0) mAcc[mvSel] = bus;
  endtask

  task automatic compareAll();
    check("R2",  "accA",     int'(accA),     mAcc[0]);
    check("R9",  "accB",     int'(accB),     mAcc[1]);
    check("R5",  "flagsA",   int'(flagsA),   int'(mFlg[0]));
    check("R7",  "flagsB",   int'(flagsB),   int'(mFlg[1]));
    check("R11", "satConst", int'(satConst), mSgn ? 16'h8000 : 16'h7FFF);
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic cycle(input int op, input int src, input int sel, input int mv, input int mvSel,
                       input int ram, input int bus, input int mh, input int ml);
    opCode = op[3:0]; srcSel = src[1:0]; accSel = sel[0]; moveEn = mv[0]; moveSel = mvSel[0];
    ramWord = ram[15:0]; busWord = bus[15:0]; mulHigh = mh[15:0]; mulLow = ml[15:0];
    @(posedge clk);
    @(negedge clk);
    modelStep(op, src, sel, mv, mvSel, ram, bus, mh, ml);
    compareAll();
  endtask

  task automatic aluOn(input int op, input int src, input int sel, input int val);
    cycle(op, src, sel, 0, 0, val, val, val, val);
  endtask

  function automatic int edgeWord();
    case ($urandom_range(0, 5))
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h0001;
      default: return int'($urandom_range(0, 65535));
    endcase
  endfunction

  initial begin
    #500000;
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    rstN = 0; opCode = 0; srcSel = 0; accSel = 0; moveEn = 0; moveSel = 0;
    ramWord = 0; busWord = 0; mulHigh = 0; mulLow = 0;
    mAcc[0] = 0; mAcc[1] = 0; mFlg[0] = 0; mFlg[1] = 0; mSgn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "accA reset",  int'(accA), 0);
    check("R1", "accB reset",  int'(accB), 0);
    check("R1", "flags reset", int'({flagsA, flagsB}), 0);
    check("R1", "sat reset",   int'(satConst), 16'h7FFF);
    rstN = 1;
    @(negedge clk);

    // R10: bus move into A with ALU idle
    cycle(0, 0, 0, 1, 0, 0, 16'h7000, 0, 0);
    check("R10", "move A", int'(accA), 16'h7000);
    // R4 R7: chained overflows on A that come back into range
    aluOn(5, 1, 0, 16'h7000);
    check("R7", "ovf1 acc", int'(accA), 16'hE000);
    check("R7", "ovf1 flags", int'(flagsA), 6'h13);
    aluOn(5, 1, 0, 16'h9000);
    check("R7", "ovf2 flags", int'(flagsA), 6'h09);
    aluOn(5, 1, 0, 16'h9000);
    check("R5", "zero flags", int'(flagsA), 6'h0C);
    aluOn(4, 1, 0, 16'h8000);
    check("R4", "sub ovf acc", int'(accA), 16'h8000);
    check("R4", "sub ovf flags", int'(flagsA), 6'h1B);
    aluOn(5, 1, 0, 16'hFFFF);
    check("R7", "back in range acc", int'(accA), 16'h7FFF);
    check("R7", "back in range flags", int'(flagsA), 6'h09);
    // R11: negative true result selects 8000h
    cycle(0, 0, 0, 1, 0, 0, 16'h8000, 0, 0);
    aluOn(4, 0, 0, 16'h0001);
    check("R11", "neg flags", int'(flagsA), 6'h23);
    check("R11", "neg sat", int'(satConst), 16'h8000);
    // R11 R9: B work leaves sign register and A alone
    cycle(0, 0, 0, 1, 1, 0, 16'h1234, 0, 0);
    cycle(5, 2, 1, 0, 0, 0, 0, 16'h7000, 0);
    check("R9", "B add acc", int'(accB), 16'h8234);
    check("R9", "B add flags", int'(flagsB), 6'h13);
    check("R11", "sat kept", int'(satConst), 16'h8000);
    check("R9", "A untouched", int'(accA), 16'h7FFF);
    // R10: move to the ALU's own accumulator suppresses the ALU
    cycle(5, 1, 1, 1, 1, 0, 16'h0055, 0, 0);
    check("R10", "suppressed acc", int'(accB), 16'h0055);
    check("R10", "suppressed flags", int'(flagsB), 6'h13);
    // R10: move to the other accumulator while ALU runs
    cycle(9, 0, 1, 1, 0, 0, 16'h0AAA, 0, 0);
    check("R10", "parallel move", int'(accA), 16'h0AAA);
    check("R10", "parallel alu", int'(accB), 16'h0056);
    // R3 R6: low product word operand, logic clears flags
    cycle(0, 0, 0, 1, 0, 0, 16'h7FFF, 0, 0);
    cycle(2, 3, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0F0F);
    check("R3", "and N", int'(accA), 16'h0F0F);
    check("R6", "and flags", int'(flagsA), 0);
    // R3: unary op ignores the operand
    cycle(9, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    check("R3", "inc ignores operand", int'(accA), 16'h0F10);
    // R4: SBB and ADC use A's own carry
    cycle(0, 0, 0, 1, 0, 0, 16'h0005, 0, 0);
    aluOn(4, 0, 0, 16'h0006);
    check("R4", "borrow flags", int'(flagsA), 6'h38);
    aluOn(6, 0, 0, 16'h0001);
    check("R4", "sbb acc", int'(accA), 16'hFFFD);
    aluOn(5, 0, 0, 16'h0007);
    check("R4", "carry flags", int'(flagsA), 6'h08);
    aluOn(7, 0, 0, 16'h0001);
    check("R4", "adc acc", int'(accA), 16'h0006);
    // R2: shifts, swap, complement
    cycle(0, 0, 0, 1, 0, 0, 16'h8421, 0, 0);
    aluOn(11, 0, 0, 0);
    check("R2", "shr1", int'(accA), 16'hC210);
    check("R6", "shr1 flags", int'(flagsA), 6'h30);
    aluOn(14, 0, 0, 0);
    check("R2", "shl4", int'(accA), 16'h2100);
    aluOn(15, 0, 0, 0);
    check("R2", "swap", int'(accA), 16'h0021);
    aluOn(10, 0, 0, 0);
    check("R2", "cpl", int'(accA), 16'hFFDE);
    // R8: NOP holds
    cycle(0, 1, 0, 0, 0, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    check("R8", "nop acc", int'(accA), 16'hFFDE);
    check("R8", "nop flags", int'(flagsA), 6'h30);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int mv;
      mv = ($urandom_range(0, 4) == 0) ? 1 : 0;
      cycle(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
            mv, int'($urandom_range(0, 1)), edgeWord(), edgeWord(), edgeWord(), edgeWord());
    end

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule